// File: doc/BRIEF.md
# Write-Busy Status Readback Generator

This block forms the byte returned to the host on every read of a byte-wide nonvolatile memory. While the internal programming cycle runs, the host has no interrupt pin. It learns that programming has finished by reading the part repeatedly. While the write controller reports busy, a read returns a status word instead of plain array data. Bit 7 carries the inverse of the bit 7 that was last written when the host reads that byte's address. Bit 6 changes value on every new read. All other bits come straight from the array. When busy drops, reads return the stored byte unchanged.

The busy flag comes from the write controller. That controller raises it for a real programming cycle and also for a write attempt that software protection blocked, so both cases produce the same polling behaviour here. The block decodes the bus strobes, returns the registered read byte one clock after the read strobe is sampled, and raises an output enable only for a valid read. When that enable is low, the pad logic floats the bus.

The control is a two-state machine. `ST_IDLE` means no programming is running and reads pass through. `ST_BUSY` means programming is in progress and reads return status. Transition `T_START` (`ST_IDLE` to `ST_BUSY`) is taken when busy is seen in idle, and it clears the bit 6 toggle. Transition `T_DONE` (`ST_BUSY` to `ST_IDLE`) is taken when busy falls. Both states hold on any other input.

Top module: `poll_status_rd`

## Requirements
- R1: During reset and on the first cycle after it, `dq_oe_o` is 0 and `dq_o` is 8'h00.
- R2: A read is recognised when `ce_n_i`=0, `oe_n_i`=0 and `we_n_i`=1 are sampled at a clock edge. After that edge `dq_oe_o`=1. If `ce_n_i` or `oe_n_i` is high, or `we_n_i` is low, then after the edge `dq_oe_o`=0 and `dq_o`=8'h00.
- R3: While busy is low, a read returns `arr_i` unchanged on all 8 bits.
- R4: While busy is high, a read whose `rd_addr_i` equals `wr_addr_i` returns the inverse of `wr_data_i[7]` on bit 7.
- R5: While busy is high, a read of any other address returns `arr_i[7]` on bit 7.
- R6: While busy is high, bits 5..0 of a read equal `arr_i[5:0]`.
- R7: While busy is high, bit 6 is 1 on the first read after busy begins and inverts at the start of each later read. A read start is a clock edge at which the read condition holds after an edge at which it did not. Bit 6 stays constant while one read is held for several cycles, and a deselected cycle does not advance it. Polling may begin at any point in the busy period.
- R8: Each new busy period restarts bit 6, so the first read of that period again returns 1.
- R9: Once busy is low again, reads return true array data on all bits, including bits 7 and 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Active-low synchronous reset |
| busy_i | input | 1 | Programming cycle in progress, from the write controller |
| ce_n_i | input | 1 | Chip enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| we_n_i | input | 1 | Write enable, active low |
| rd_addr_i | input | ADDR_W | Address currently presented by the host |
| arr_i | input | 8 | Stored array byte at `rd_addr_i` |
| wr_addr_i | input | ADDR_W | Address of the last byte written |
| wr_data_i | input | 8 | Data of the last byte written |
| dq_o | output | 8 | Read byte returned to the bus |
| dq_oe_o | output | 1 | Bus drive enable; low floats the bus |

## Verification
The strobe combinations that should not read each isolate one term of the read decode: chip deselected, output disabled, and write enable low. Busy reads use the last written address and an unrelated address with array bytes of both bit 7 polarities. This separates the inverted bit 7 from pass-through and confirms that bits 5..0 are untouched. A read is held for several cycles, and reads are interleaved with deselected cycles. These patterns tell per-read toggling apart from per-clock toggling. A second busy period shows the restart of bit 6, and reads after busy falls show that status stops.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
    localparam int unsigned DATA_W   = 8;
    localparam int unsigned POLL_BIT = 7;
    localparam int unsigned TOG_BIT  = 6;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } rbs_state_e;
endpackage

// File: rtl/rbs_strobe.sv
module rbs_strobe (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic ce_n_i,
    input  logic oe_n_i,
    input  logic we_n_i,
    output logic rd_act_o,
    output logic rd_start_o
);
    logic rd_prev_q;

    assign rd_act_o   = !ce_n_i && !oe_n_i && we_n_i;
    assign rd_start_o = rd_act_o && !rd_prev_q;

    always_ff @(posedge clk_i) begin
        if (!rst_n_i) rd_prev_q <= 1'b0;
        else          rd_prev_q <= rd_act_o;
    end
endmodule

// File: rtl/rbs_toggle.sv
module rbs_toggle (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic clr_i,
    input  logic adv_i,
    output logic tog_nx_o,
    output logic tog_q_o
);
    logic base;

    always_comb begin
        base     = clr_i ? 1'b0 : tog_q_o;
        tog_nx_o = adv_i ? ~base : base;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_n_i) tog_q_o <= 1'b0;
        else          tog_q_o <= tog_nx_o;
    end

    // R7
    tog_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (adv_i && !clr_i) |=> (tog_q_o != $past(tog_q_o)));

    // R7
    tog_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (!adv_i && !clr_i) |=> $stable(tog_q_o));

    // R8
    tog_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (clr_i && !adv_i) |=> !tog_q_o);
endmodule

// File: rtl/poll_status_rd.sv
module poll_status_rd
    import rbs_pkg::*;
#(
    parameter int unsigned ADDR_W = 17
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              busy_i,
    input  logic              ce_n_i,
    input  logic              oe_n_i,
    input  logic              we_n_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic [DATA_W-1:0] arr_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_oe_o
);
    rbs_state_e        state_q, state_d;
    logic              rd_act, rd_start;
    logic              enter_busy;
    logic              tog_nx, tog_q;
    logic              addr_hit;
    logic [DATA_W-1:0] status_word;

    rbs_strobe u_strobe (
        .clk_i      (clk_i),
        .rst_n_i    (rst_n_i),
        .ce_n_i     (ce_n_i),
        .oe_n_i     (oe_n_i),
        .we_n_i     (we_n_i),
        .rd_act_o   (rd_act),
        .rd_start_o (rd_start)
    );

    assign enter_busy = (state_q == ST_IDLE) && busy_i;

    rbs_toggle u_toggle (
        .clk_i    (clk_i),
        .rst_n_i  (rst_n_i),
        .clr_i    (enter_busy),
        .adv_i    (rd_start && busy_i),
        .tog_nx_o (tog_nx),
        .tog_q_o  (tog_q)
    );

    // State transitions: T_START and T_DONE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (busy_i)  state_d = ST_BUSY;
            ST_BUSY: if (!busy_i) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_n_i) state_q <= ST_IDLE;
        else          state_q <= state_d;
    end

    assign addr_hit = (rd_addr_i == wr_addr_i);

    always_comb begin
        status_word           = arr_i;
        status_word[POLL_BIT] = addr_hit ? ~wr_data_i[POLL_BIT] : arr_i[POLL_BIT];
        status_word[TOG_BIT]  = tog_nx;
    end

    // Output register
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            dq_o    <= '0;
            dq_oe_o <= 1'b0;
        end else if (!rd_act) begin
            dq_o    <= '0;
            dq_oe_o <= 1'b0;
        end else begin
            dq_oe_o <= 1'b1;
            dq_o    <= busy_i ? status_word : arr_i;
        end
    end

    // R2
    rd_off_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !rd_act |=> (!dq_oe_o && dq_o == '0));

    // R2
    rd_on_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        rd_act |=> dq_oe_o);

    // R3
    idle_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (rd_act && !busy_i) |=> (dq_o == $past(arr_i)));

    // R4
    poll_inv_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (rd_act && busy_i && rd_addr_i == wr_addr_i) |=> (dq_o[POLL_BIT] != $past(wr_data_i[POLL_BIT])));

    // R6
    low_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        rd_act |=> (dq_o[5:0] == $past(arr_i[5:0])));

    // R8
    busy_enter_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (state_q == ST_IDLE && busy_i) |=> (state_q == ST_BUSY));
endmodule

// File: tb/poll_status_rd_tb_top.sv
module poll_status_rd_tb_top;
    localparam int ADDR_W = 17;
    localparam int VW     = 4 + ADDR_W + 8 + 1 + 8;
    localparam int NV     = 12;
    localparam logic [ADDR_W-1:0] WA = 17'h00015;
    localparam logic [7:0]        WD = 8'hA5;

    // {busy, ce_n, oe_n, we_n, addr, arr, exp_oe, exp_dq}
    localparam logic [VW-1:0] VEC [NV] = '{
        {4'b0001, 17'h00015, 8'hC3, 1'b1, 8'hC3},  // R3 idle pass
        {4'b0101, 17'h00015, 8'hC3, 1'b0, 8'h00},  // R2 ce high
        {4'b0011, 17'h00015, 8'hC3, 1'b0, 8'h00},  // R2 oe high
        {4'b0000, 17'h00015, 8'hC3, 1'b0, 8'h00},  // R2 we low
        {4'b1001, 17'h00015, 8'hC3, 1'b1, 8'h43},  // R4 R7 first poll
        {4'b1001, 17'h00015, 8'h3C, 1'b1, 8'h3C},  // R4 R6 R7 second
        {4'b1001, 17'h00020, 8'h80, 1'b1, 8'hC0},  // R5 other addr
        {4'b1101, 17'h00020, 8'h80, 1'b0, 8'h00},  // R2 R7 deselect
        {4'b1001, 17'h00020, 8'h00, 1'b1, 8'h00},  // R5 R7 toggled
        {4'b0001, 17'h00015, 8'hA5, 1'b1, 8'hA5},  // R9 true data
        {4'b0001, 17'h00015, 8'h7F, 1'b1, 8'h7F},  // R9
        {4'b1001, 17'h00015, 8'hFF, 1'b1, 8'h7F}   // R8 restart
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic              busy, ce_n, oe_n, we_n;
    logic [ADDR_W-1:0] rd_addr;
    logic [7:0]        arr;
    logic [7:0]        dq;
    logic              dq_oe;
    int                n_chk = 0;
    int                n_err = 0;
    bit                done  = 1'b0;

    always #2 clk = ~clk;

    poll_status_rd #(.ADDR_W(ADDR_W)) dut_i (
        .clk_i     (clk),
        .rst_n_i   (rst_n),
        .busy_i    (busy),
        .ce_n_i    (ce_n),
        .oe_n_i    (oe_n),
        .we_n_i    (we_n),
        .rd_addr_i (rd_addr),
        .arr_i     (arr),
        .wr_addr_i (WA),
        .wr_data_i (WD),
        .dq_o      (dq),
        .dq_oe_o   (dq_oe)
    );

    task automatic check(input string req, input logic oe_exp, input logic [7:0] dq_exp);
        n_chk++;
        if (dq_oe !== oe_exp || dq !== dq_exp) begin
            n_err++;
            $display("FAIL %s: oe=%0b dq=%h expected oe=%0b dq=%h", req, dq_oe, dq, oe_exp, dq_exp);
        end
    endtask

    task automatic deselect(input logic b);
        busy = b; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; rd_addr = a; arr = d;
        @(posedge clk); @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; busy = 1'b0; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
        rd_addr = '0; arr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 in reset", 1'b0, 8'h00);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R1 after reset", 1'b0, 8'h00);

        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            v = VEC[i];
            deselect(v[VW-1]);
            ce_n = v[VW-2]; oe_n = v[VW-3]; we_n = v[VW-4];
            rd_addr = v[VW-5 -: ADDR_W];
            arr = v[16:9];
            @(posedge clk); @(negedge clk);
            check($sformatf("table %0d", i), v[8], v[7:0]);
        end

        // R7 held read: bit 6 constant over several cycles
        deselect(1'b0);
        deselect(1'b1);
        rd(17'h00100, 8'h00);
        check("R7 held read c0", 1'b1, 8'h40);
        rd(17'h00100, 8'h00);
        check("R7 held read c1", 1'b1, 8'h40);
        rd(17'h00100, 8'h00);
        check("R7 held read c2", 1'b1, 8'h40);
        deselect(1'b1);
        rd(17'h00100, 8'h00);
        check("R7 next read flips", 1'b1, 8'h00);

        // R7 polling begins late in a new busy period; R8 restart
        deselect(1'b0);
        repeat (5) deselect(1'b1);
        rd(WA, 8'h25);
        check("R7 R8 late first poll", 1'b1, 8'h65);
        deselect(1'b1);
        rd(WA, 8'h25);
        check("R4 R7 second poll", 1'b1, 8'h25);

        // R9 after busy ends
        deselect(1'b0);
        rd(WA, 8'hE6);
        check("R9 true data", 1'b1, 8'hE6);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: run did not complete, expected completion");
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule